// File: doc/BRIEF.md
# Per-VC Cut-Through Cell Dispatcher

This block is one stage of a chain of cell-handling stages placed in front of a switch port. Cells arrive on two upstream inputs and are looked up by their virtual channel number in a table with one entry per channel. The entry decides where the cell goes: on along the chain toward the switch, into the attached processor's memory port, or to both. A channel that this stage does not own passes through untouched. A channel that it owns starts out diverted to software. Once software has drained the backlog for that flow and set the forwarding flag, the channel's cells cut straight through.

Each channel entry also carries an activity state for pre-provisioned channels. The first cell seen on an idle channel flips it to active on its own, and that cell goes to the processor. A control cell with a dedicated payload-type code returns an owned channel to idle and clears its forwarding flag, so later traffic on that channel is handled in software again. A host port writes whole entries. The write is visible to the next cell lookup, and a cell already in flight keeps the route it was given at its first beat.

A cell is a fixed number of beats. The channel number and payload type are read from the first beat only. The control is a three-state machine. ST_IDLE arbitrates between the inputs and accepts a header beat. The transition take_pass goes to ST_PASS when the cell has at least one destination. The transition take_sink goes to ST_SINK when the cell is a reset control cell. Both busy states accept the remaining beats of the chosen input and take the transition cell_done back to ST_IDLE on the last beat.

Top module: `cut_dispatch`

## Requirements
- R1: After reset every channel entry is cleared (not owned, idle, no forwarding, no duplication), all outputs are low, and a cell on any channel leaves on the chain output.
- R2: A cell on a channel whose owned bit is 0 leaves only on the chain output, with its data and channel number unchanged, one cycle after each beat is accepted.
- R3: The first cell on an owned, idle channel goes only to the memory port, and the channel becomes active.
- R4: On an owned, active channel, forwarding flag 1 with duplication 0 sends cells only to the chain output, and forwarding flag 0 sends them only to the memory port.
- R5: On an owned, active channel with forwarding flag 1 and duplication 1, every beat appears on both the chain output and the memory port in the same cycle.
- R6: A cell with payload type 3'b110 on an owned channel produces no output beats and clears that channel's active and forwarding bits, so the next cell goes to memory. The same code on a channel that is not owned is forwarded on the chain like any other cell.
- R7: When both inputs offer a header in the same idle cycle, they are served alternately, starting with input 0 after reset. A single requester is served at once. Only the selected input is ready until its cell ends.
- R8: The route of a cell is fixed at its first beat. A host write to that channel during the cell does not change where the remaining beats go.
- R9: The host write data maps bit 3 to owned, bit 2 to active, bit 1 to forwarding and bit 0 to duplication. A host write that lands on the same entry in the same cycle as an automatic state change wins.
- R10: A cell is CELL_BEATS beats long. The channel number and payload type are taken from the first beat only. The sop output marks the first beat, and the vci output carries the first beat's channel for every beat of the cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in0_valid | input | 1 | Input 0 offers a beat |
| in0_ready | output | 1 | Input 0 beat accepted this cycle |
| in0_data | input | DATA_W | Input 0 beat data |
| in0_vci | input | VCI_W | Input 0 channel number (first beat) |
| in0_pti | input | 3 | Input 0 payload type (first beat) |
| in1_valid | input | 1 | Input 1 offers a beat |
| in1_ready | output | 1 | Input 1 beat accepted this cycle |
| in1_data | input | DATA_W | Input 1 beat data |
| in1_vci | input | VCI_W | Input 1 channel number (first beat) |
| in1_pti | input | 3 | Input 1 payload type (first beat) |
| host_wr | input | 1 | Host entry write strobe |
| host_addr | input | VCI_W | Channel entry to write |
| host_wdata | input | 4 | New entry {owned, active, fwd, dup} |
| chain_valid | output | 1 | Beat on the chain output |
| chain_sop | output | 1 | First beat of a cell on the chain output |
| chain_data | output | DATA_W | Chain output data |
| chain_vci | output | VCI_W | Channel of the cell on the chain output |
| mem_valid | output | 1 | Beat on the memory port |
| mem_sop | output | 1 | First beat of a cell on the memory port |
| mem_data | output | DATA_W | Memory port data |
| mem_vci | output | VCI_W | Channel of the cell on the memory port |

## Verification
The bench goes after the activity flip on the first cell, the reset control cell on owned and on unowned channels, and a host write that collides with the automatic state change on the same entry. A design that got these wrong would keep sending a new flow to software forever, leak reset cells downstream, or let the hardware update overwrite the host. It also rewrites a channel's entry in the middle of a cell, which exposes a route that is re-read per beat, and it sends later beats with scrambled headers, which exposes header sampling past the first beat. Contested and gapped traffic on both inputs checks that ready alternates fairly and never moves to the other input in the middle of a cell.

// File: rtl/cut_disp_pkg.sv
package cut_disp_pkg;

    localparam int PTI_W = 3;
    localparam logic [PTI_W-1:0] PTI_RESET = 3'b110;

    // bit 3 owned, bit 2 active, bit 1 fwd, bit 0 dup
    typedef struct packed {
        logic owned;
        logic active;
        logic fwd;
        logic dup;
    } vc_entry_t;

    typedef struct packed {
        logic to_chain;
        logic to_mem;
    } route_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_SINK = 2'd2
    } disp_state_e;

endpackage

// File: rtl/cd_rr_arb.sv
module cd_rr_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       take,
    output logic [1:0] gnt
);

    logic pref_q;   // input preferred on contention

    always_comb begin
        unique case (req)
            2'b00:   gnt = 2'b00;
            2'b01:   gnt = 2'b01;
            2'b10:   gnt = 2'b10;
            default: gnt = pref_q ? 2'b10 : 2'b01;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pref_q <= 1'b0;
        end else if (take && (|gnt)) begin
            pref_q <= gnt[0];
        end
    end

    a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r7_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gnt & ~req)) == 1'b0);

    a_r7_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req == 2'b11 && gnt == 2'b01) |=> (req == 2'b11) |-> gnt == 2'b10);

endmodule

// File: rtl/cd_vc_table.sv
module cd_vc_table
    import cut_disp_pkg::*;
#(
    parameter int VCI_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VCI_W-1:0] rd_addr,
    output vc_entry_t        rd_entry,
    input  logic             upd_en,
    input  logic [VCI_W-1:0] upd_addr,
    input  vc_entry_t        upd_entry,
    input  logic             host_wr,
    input  logic [VCI_W-1:0] host_addr,
    input  vc_entry_t        host_entry
);

    localparam int DEPTH = 1 << VCI_W;

    vc_entry_t ents [DEPTH];
    logic      clash;

    assign rd_entry = ents[rd_addr];
    assign clash    = host_wr && (host_addr == upd_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ents[i] <= '0;
            end
        end else begin
            if (upd_en && !clash) begin
                ents[upd_addr] <= upd_entry;
            end
            if (host_wr) begin
                ents[host_addr] <= host_entry;
            end
        end
    end

    // R9: host write wins over a same-entry automatic update
    a_r9_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && upd_en && host_addr == upd_addr)
        |=> ents[$past(host_addr)] == $past(host_entry));

endmodule

// File: rtl/cd_route_decide.sv
module cd_route_decide
    import cut_disp_pkg::*;
(
    input  vc_entry_t        ent,
    input  logic [PTI_W-1:0] pti,
    output route_t           route,
    output logic             sink,
    output logic             upd_en,
    output vc_entry_t        upd_entry
);

    always_comb begin
        route     = '0;
        sink      = 1'b0;
        upd_en    = 1'b0;
        upd_entry = ent;
        if (!ent.owned) begin
            route.to_chain = 1'b1;
        end else if (pti == PTI_RESET) begin
            sink             = 1'b1;
            upd_en           = 1'b1;
            upd_entry.active = 1'b0;
            upd_entry.fwd    = 1'b0;
        end else if (!ent.active) begin
            route.to_mem     = 1'b1;
            upd_en           = 1'b1;
            upd_entry.active = 1'b1;
        end else if (ent.fwd) begin
            route.to_chain = 1'b1;
            route.to_mem   = ent.dup;
        end else begin
            route.to_mem = 1'b1;
        end
    end

endmodule

// File: rtl/cut_dispatch.sv
module cut_dispatch
    import cut_disp_pkg::*;
#(
    parameter int VCI_W      = 10,
    parameter int DATA_W     = 32,
    parameter int CELL_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in0_valid,
    output logic              in0_ready,
    input  logic [DATA_W-1:0] in0_data,
    input  logic [VCI_W-1:0]  in0_vci,
    input  logic [2:0]        in0_pti,
    input  logic              in1_valid,
    output logic              in1_ready,
    input  logic [DATA_W-1:0] in1_data,
    input  logic [VCI_W-1:0]  in1_vci,
    input  logic [2:0]        in1_pti,
    input  logic              host_wr,
    input  logic [VCI_W-1:0]  host_addr,
    input  logic [3:0]        host_wdata,
    output logic              chain_valid,
    output logic              chain_sop,
    output logic [DATA_W-1:0] chain_data,
    output logic [VCI_W-1:0]  chain_vci,
    output logic              mem_valid,
    output logic              mem_sop,
    output logic [DATA_W-1:0] mem_data,
    output logic [VCI_W-1:0]  mem_vci
);

    localparam int CNT_W = (CELL_BEATS > 2) ? $clog2(CELL_BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(CELL_BEATS - 1);

    disp_state_e      state_q, state_d;
    logic [1:0]       gnt;
    logic             idle, hdr_acc, body_valid, body_acc, beat_acc, last_beat;
    logic             sel_q;
    route_t           route_q, dec_route, route_now;
    logic             dec_sink, dec_upd_en;
    vc_entry_t        dec_upd_entry, rd_entry;
    logic [VCI_W-1:0] hdr_vci, vci_q, beat_vci;
    logic [PTI_W-1:0] hdr_pti;
    logic [DATA_W-1:0] beat_data;
    logic [CNT_W-1:0] cnt_q;

    assign idle       = (state_q == ST_IDLE);
    assign hdr_acc    = idle && (|gnt);
    assign body_valid = sel_q ? in1_valid : in0_valid;
    assign body_acc   = !idle && body_valid;
    assign beat_acc   = hdr_acc || body_acc;
    assign last_beat  = (cnt_q == LAST_BEAT);

    assign hdr_vci   = gnt[1] ? in1_vci : in0_vci;
    assign hdr_pti   = gnt[1] ? in1_pti : in0_pti;
    assign beat_data = idle ? (gnt[1] ? in1_data : in0_data)
                            : (sel_q ? in1_data : in0_data);
    assign beat_vci  = idle ? hdr_vci : vci_q;
    assign route_now = idle ? dec_route : route_q;

    assign in0_ready = idle ? gnt[0] : !sel_q;
    assign in1_ready = idle ? gnt[1] : sel_q;

    cd_rr_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   ({in1_valid, in0_valid}),
        .take  (hdr_acc),
        .gnt   (gnt)
    );

    cd_vc_table #(.VCI_W(VCI_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (hdr_vci),
        .rd_entry   (rd_entry),
        .upd_en     (hdr_acc && dec_upd_en),
        .upd_addr   (hdr_vci),
        .upd_entry  (dec_upd_entry),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_entry (vc_entry_t'(host_wdata))
    );

    cd_route_decide u_decide (
        .ent       (rd_entry),
        .pti       (hdr_pti),
        .route     (dec_route),
        .sink      (dec_sink),
        .upd_en    (dec_upd_en),
        .upd_entry (dec_upd_entry)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hdr_acc) begin
                    state_d = dec_sink ? ST_SINK : ST_PASS;   // take_sink / take_pass
                end
            end
            ST_PASS, ST_SINK: begin
                if (body_acc && last_beat) begin
                    state_d = ST_IDLE;                        // cell_done
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and per-cell context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= 1'b0;
            route_q <= '0;
            vci_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (hdr_acc) begin
                sel_q   <= gnt[1];
                route_q <= dec_route;
                vci_q   <= hdr_vci;
                cnt_q   <= CNT_W'(1);
            end else if (body_acc) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_valid <= 1'b0;
            chain_sop   <= 1'b0;
            chain_data  <= '0;
            chain_vci   <= '0;
            mem_valid   <= 1'b0;
            mem_sop     <= 1'b0;
            mem_data    <= '0;
            mem_vci     <= '0;
        end else begin
            chain_valid <= beat_acc && route_now.to_chain;
            chain_sop   <= hdr_acc && route_now.to_chain;
            chain_data  <= beat_data;
            chain_vci   <= beat_vci;
            mem_valid   <= beat_acc && route_now.to_mem;
            mem_sop     <= hdr_acc && route_now.to_mem;
            mem_data    <= beat_data;
            mem_vci     <= beat_vci;
        end
    end

    a_r2_unowned_to_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_acc && !rd_entry.owned) |=> (chain_valid && chain_sop && !mem_valid));

    a_r3_idle_vc_to_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_acc && rd_entry.owned && !rd_entry.active && hdr_pti != PTI_RESET)
        |=> (mem_valid && mem_sop && !chain_valid));

    a_r6_reset_cell_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_acc && rd_entry.owned && hdr_pti == PTI_RESET) |=> (!chain_valid && !mem_valid));

    a_r7_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !(in0_ready && in1_ready));

    a_r10_sop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_sop || chain_valid) && (!mem_sop || mem_valid));

endmodule

// File: tb/cut_dispatch_tb_top.sv
module cut_dispatch_tb_top;

    localparam int VCI_W      = 10;
    localparam int DATA_W     = 32;
    localparam int CELL_BEATS = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              in0_valid, in0_ready, in1_valid, in1_ready;
    logic [DATA_W-1:0] in0_data, in1_data;
    logic [VCI_W-1:0]  in0_vci, in1_vci;
    logic [2:0]        in0_pti, in1_pti;
    logic              host_wr;
    logic [VCI_W-1:0]  host_addr;
    logic [3:0]        host_wdata;
    logic              chain_valid, chain_sop, mem_valid, mem_sop;
    logic [DATA_W-1:0] chain_data, mem_data;
    logic [VCI_W-1:0]  chain_vci, mem_vci;

    cut_dispatch #(.VCI_W(VCI_W), .DATA_W(DATA_W), .CELL_BEATS(CELL_BEATS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in0_valid(in0_valid), .in0_ready(in0_ready), .in0_data(in0_data),
        .in0_vci(in0_vci), .in0_pti(in0_pti),
        .in1_valid(in1_valid), .in1_ready(in1_ready), .in1_data(in1_data),
        .in1_vci(in1_vci), .in1_pti(in1_pti),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .chain_valid(chain_valid), .chain_sop(chain_sop), .chain_data(chain_data),
        .chain_vci(chain_vci),
        .mem_valid(mem_valid), .mem_sop(mem_sop), .mem_data(mem_data), .mem_vci(mem_vci)
    );

    typedef struct {
        logic [VCI_W-1:0]  vci;
        logic [2:0]        pti;
        logic [DATA_W-1:0] data;
    } beat_t;

    beat_t q0[$];
    beat_t q1[$];

    // behavioural reference state
    logic [3:0]       mt [0:(1<<VCI_W)-1];
    bit               m_busy, m_sel, m_rr, m_rc, m_rm;
    int               m_cnt;
    logic [VCI_W-1:0] m_vci;
    string            m_tag;

    bit                e_cv, e_mv, e_sop;
    logic [DATA_W-1:0] e_data;
    logic [VCI_W-1:0]  e_vci;
    string             e_tag;

    int    n_chk, n_fail, cyc;
    bit    done, gappy;
    string phase;
    bit               hw;
    logic [VCI_W-1:0] ha;
    logic [3:0]       hd;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tagof(string t);
        return (phase == "") ? t : {t, "/", phase};
    endfunction

    task automatic send_cell(int port, int vci, int pti, int tag);
        for (int b = 0; b < CELL_BEATS; b++) begin
            beat_t x;
            // R10: later beats carry scrambled header fields
            x.vci  = (b == 0) ? VCI_W'(vci) : ~VCI_W'(vci);
            x.pti  = (b == 0) ? 3'(pti) : 3'(~pti);
            x.data = DATA_W'(tag * 16 + b);
            if (port == 0) q0.push_back(x); else q1.push_back(x);
        end
    endtask

    task automatic decide(logic [VCI_W-1:0] vci, logic [2:0] pti);
        logic [3:0] e;
        e = mt[vci];
        m_rc = 0; m_rm = 0;
        if (!e[3]) begin
            m_rc = 1; m_tag = "R2";
        end else if (pti == 3'b110) begin
            mt[vci][2] = 1'b0; mt[vci][1] = 1'b0; m_tag = "R6";
        end else if (!e[2]) begin
            m_rm = 1; mt[vci][2] = 1'b1; m_tag = "R3";
        end else if (e[1]) begin
            m_rc = 1; m_rm = e[0]; m_tag = e[0] ? "R5" : "R4";
        end else begin
            m_rm = 1; m_tag = "R4";
        end
    endtask

    task automatic step();
        bit r0, r1, a0, a1;
        beat_t b;
        @(negedge clk);
        cyc++;
        // compare outputs registered at the previous edge
        if (e_cv) check(tagof(e_tag), {20'd0, chain_valid, chain_sop, chain_data, chain_vci},
                        {20'd0, 1'b1, e_sop, e_data, e_vci}, "chain beat");
        else      check(tagof(e_tag), 64'(chain_valid), 64'd0, "chain idle");
        if (e_mv) check(tagof(e_tag), {20'd0, mem_valid, mem_sop, mem_data, mem_vci},
                        {20'd0, 1'b1, e_sop, e_data, e_vci}, "mem beat");
        else      check(tagof(e_tag), 64'(mem_valid), 64'd0, "mem idle");
        // drive
        in0_valid = (q0.size() > 0) && !(gappy && ((cyc * 3) % 4 == 0));
        in1_valid = (q1.size() > 0) && !(gappy && ((cyc * 5 + 1) % 3 == 0));
        if (q0.size() > 0) begin in0_data = q0[0].data; in0_vci = q0[0].vci; in0_pti = q0[0].pti; end
        if (q1.size() > 0) begin in1_data = q1[0].data; in1_vci = q1[0].vci; in1_pti = q1[0].pti; end
        host_wr = hw; host_addr = ha; host_wdata = hd;
        hw = 0;
        #1;
        if (!m_busy) begin
            if (in0_valid && in1_valid) begin r0 = !m_rr; r1 = m_rr; end
            else begin r0 = in0_valid; r1 = in1_valid; end
        end else begin
            r0 = !m_sel; r1 = m_sel;
        end
        check(tagof("R7"), {62'd0, in1_ready, in0_ready}, {62'd0, r1, r0}, "ready");
        a0 = r0 && in0_valid;
        a1 = r1 && in1_valid;
        e_cv = 0; e_mv = 0; e_sop = 0; e_tag = "R10";
        if (a0 || a1) begin
            b = a1 ? q1.pop_front() : q0.pop_front();
            if (!m_busy) begin
                decide(b.vci, b.pti);
                m_busy = 1; m_sel = a1; m_rr = !a1; m_cnt = 1; m_vci = b.vci; e_sop = 1;
            end else begin
                m_cnt++;
            end
            if (m_cnt == CELL_BEATS) m_busy = 0;
            e_cv = m_rc; e_mv = m_rm; e_data = b.data; e_vci = m_vci; e_tag = m_tag;
        end
        if (host_wr) mt[host_addr] = host_wdata;
    endtask

    task automatic drain();
        while (q0.size() > 0 || q1.size() > 0 || m_busy) step();
        step();
        step();
    endtask

    task automatic host_write(int a, int d);
        hw = 1; ha = VCI_W'(a); hd = 4'(d);
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << VCI_W); i++) mt[i] = 4'd0;
        rst_n = 0; in0_valid = 0; in1_valid = 0; host_wr = 0;
        in0_data = '0; in1_data = '0; in0_vci = '0; in1_vci = '0; in0_pti = '0; in1_pti = '0;
        host_addr = '0; host_wdata = '0;
        phase = ""; e_tag = "R10";
        repeat (3) begin
            @(negedge clk);
            check("R1", {56'd0, chain_valid, mem_valid, chain_sop, mem_sop, in0_ready, in1_ready, 2'b00},
                  64'd0, "reset outputs");
        end
        rst_n = 1;

        // R1: cleared table passes any channel to the chain
        phase = "R1";
        send_cell(0, 5, 0, 1);
        drain();
        phase = "";

        // R2 and R7: contested unowned traffic alternates
        send_cell(0, 30, 0, 2); send_cell(1, 31, 0, 3);
        send_cell(0, 32, 0, 4); send_cell(1, 33, 0, 5);
        drain();

        // R3 then R4 (fwd 0): owned, idle channel
        host_write(10, 4'b1000);
        send_cell(1, 10, 0, 6); send_cell(1, 10, 0, 7);
        drain();
        // R4: forwarding on
        host_write(10, 4'b1110);
        send_cell(0, 10, 0, 8);
        drain();

        // R5: forwarding with duplication
        host_write(11, 4'b1111);
        send_cell(0, 11, 0, 9);
        drain();

        // R6: reset cell, then re-activation in software
        send_cell(1, 11, 6, 10);
        send_cell(1, 11, 0, 11);
        send_cell(1, 11, 0, 12);
        drain();
        send_cell(0, 20, 6, 13);   // unowned: passes
        drain();

        // R8: host rewrites the entry in the middle of a cell
        phase = "R8";
        send_cell(0, 10, 0, 14);
        step();
        hw = 1; ha = 10; hd = 4'b1000;
        drain();
        send_cell(0, 10, 0, 15);
        drain();

        // R9: host write collides with the automatic activation
        phase = "R9";
        host_write(12, 4'b1000);
        send_cell(0, 12, 0, 16);
        hw = 1; ha = 12; hd = 4'b1010;
        step();
        drain();
        send_cell(0, 12, 0, 17);
        send_cell(0, 12, 0, 18);
        drain();
        phase = "";

        // mixed gapped traffic on both inputs
        gappy = 1;
        for (int k = 0; k < 14; k++) begin
            int vs;
            vs = (k % 5 == 0) ? 5 : (k % 5 == 1) ? 10 : (k % 5 == 2) ? 11 : (k % 5 == 3) ? 12 : 20;
            send_cell(k % 2, vs, (k == 7) ? 6 : 0, 20 + k);
        end
        drain();
        gappy = 0;

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule